// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt events from eight second-level groups into one master register and drives a single level-sensitive interrupt line. Each group owns four 32-bit registers: a read-only status view of the live event inputs, a mask that decides which events are latched, an identity register that latches accepted events until software clears them, and an enable register that selects which latched bits count toward the master summary. Every group reduces its enabled identity bits into one or two summary bits of the master register, and the top bit of the master register is a global enable for the output.

Software reaches all registers through a simple word-aligned 32-bit read/write port. Reads return data one cycle after the request. Summary bits are a level view of the groups: they follow identity and enable changes in the next cycle and cannot be written. The usual service sequence is to read the master register, read the identity register of a flagged group, then clear the serviced bits by writing ones to them.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset every mask register reads 0xFFFFFFFF, every identity and enable register reads 0, the master register reads 0 and `irq_o` is low.
- R2: An event bit high at a clock edge sets the matching identity bit only if the matching mask bit is 0; an event arriving while masked is lost and does not appear when the mask is later cleared.
- R3: Writing the identity register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R4: Writing a mask or enable register replaces all 32 bits, and the summary bits reflect a new enable value from the next cycle on.
- R5: Master summary bits are set from identity AND enable of the groups: group 0 bits 15:0 give bit 0 and bits 31:16 give bit 1; group 1 likewise gives bits 2 and 3; group 2 bits 15:0 give bit 4 and group 3 bits 15:0 give bit 6 (their upper halves drive nothing); groups 4, 5, 6 and 7 each give one bit from all 32 bits, at 16, 17, 18 and 20. All other master bits 30:0 read 0.
- R6: A write to the master register changes only bit 31; summary bits ignore written values.
- R7: `irq_o` is high exactly when master bit 31 is set and at least one of master bits 30:0 is set.
- R8: When an accepted event and a write-1-to-clear hit the same identity bit in the same cycle, the bit ends up set.
- R9: A status register read returns the event inputs of its group as sampled at the read's clock edge; writes to a status register have no effect.
- R10: Group g (0..7) occupies byte offsets 16*g + 0x0 (status), +0x4 (mask), +0x8 (identity), +0xC (enable); the master register is at 0x80; any other offset reads 0. `bus_rvalid` and `bus_rdata` are valid in the cycle after `bus_rd`, and show register values from before any write in the same cycle.
- R11: Clearing identity bits drops the summary bits they were holding, and with them `irq_o`, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 256 | Event inputs, group g in bits 32*g+31 : 32*g |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt output |

## Verification
The hardest state to reach is an event and a clear that strike the same identity bit in one cycle, since it needs the event input and the bus write aligned to the same clock edge. The bench drives all inputs together from one per-cycle task, so it can place a pulse on a group's event line in the very cycle the identity write carries a one for that bit, then read the register back. The same alignment is used to show that the status register reports the event level present at the read edge, and that an event arriving while the mask is set stays lost after unmasking.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants, register selector type and the group-to-master
// summary routing used by the aggregation controller.
// Assumes 32-bit registers and at most eleven second-level groups.
package irq_agg_pkg;

    localparam int REG_W = 32;
    localparam int POS_W = $clog2(REG_W);

    // Register selector inside a group, taken from address bits 3:2.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_IDENT  = 2'd2,
        SEL_ENABLE = 2'd3
    } grp_reg_e;

    // Where one group's reduced value lands in the master register.
    typedef struct packed {
        logic [REG_W-1:0] lo_sel;
        logic [POS_W-1:0] lo_pos;
        logic [REG_W-1:0] hi_sel;
        logic [POS_W-1:0] hi_pos;
    } route_t;

    // Routing per group index; an unused half has a zero selector.
    function automatic route_t group_route(input int g);
        route_t r;
        r = '0;
        case (g)
            0: begin r.lo_sel = 32'h0000_FFFF; r.lo_pos = 5'd0;
                     r.hi_sel = 32'hFFFF_0000; r.hi_pos = 5'd1; end
            1: begin r.lo_sel = 32'h0000_FFFF; r.lo_pos = 5'd2;
                     r.hi_sel = 32'hFFFF_0000; r.hi_pos = 5'd3; end
            2: begin r.lo_sel = 32'h0000_FFFF; r.lo_pos = 5'd4; end
            3: begin r.lo_sel = 32'h0000_FFFF; r.lo_pos = 5'd6; end
            4: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd16; end
            5: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd17; end
            6: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd18; end
            7: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd20; end
            8: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd22; end
            9: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd23; end
            10: begin r.lo_sel = 32'hFFFF_FFFF; r.lo_pos = 5'd30; end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_group.sv
// Module: one second-level interrupt group.
// Holds mask, identity and enable registers; status is the live event input
// and is not stored here. Accepted events are latched into identity; a
// write-1-to-clear loses against an event on the same bit.
// Assumes the write strobe is already decoded for this group.
module irq_group
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             wr_i,
    input  grp_reg_e         wr_sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] ident_o,
    output logic [REG_W-1:0] enable_o,
    output logic [REG_W-1:0] live_o
);

    logic [REG_W-1:0] accepted;
    logic [REG_W-1:0] clear_bits;

    // Events that pass the current mask.
    always_comb accepted = evt_i & ~mask_o;

    // Bits software asks to clear this cycle.
    always_comb clear_bits = (wr_i && wr_sel_i == SEL_IDENT) ? wdata_i : '0;

    // Mask register: full replace on write, all masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_o <= '1;
        else if (wr_i && wr_sel_i == SEL_MASK)   mask_o <= wdata_i;
    end

    // Enable register: full replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              enable_o <= '0;
        else if (wr_i && wr_sel_i == SEL_ENABLE) enable_o <= wdata_i;
    end

    // Identity register: clear first, then set accepted events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) ident_o <= '0;
        else        ident_o <= (ident_o & ~clear_bits) | accepted;
    end

    // Reduced value offered to the master summary.
    always_comb live_o = ident_o & enable_o;

    // A newly set identity bit must come from an unmasked event.
    p_masked_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ident_o & ~$past(ident_o) & ~$past(evt_i & ~mask_o)) == '0));

    // Bits cleared by software without a colliding event are gone.
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ident_o & $past(clear_bits & ~(evt_i & ~mask_o))) == '0));

    // An accepted event always leaves its bit set, even under a clear.
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_i & ~mask_o) & ~ident_o) == '0));

endmodule

// File: rtl/irq_summary.sv
// Module: reduces each group's enabled identity bits into the master
// summary bits according to the routing in the package.
// Purely combinational; assumes NUM_GRP does not exceed the routed groups.
module irq_summary
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP = 8
) (
    input  logic [NUM_GRP-1:0][REG_W-1:0] live_i,
    output logic [REG_W-2:0]              summ_o
);

    // OR every group's selected halves into their master positions.
    always_comb begin
        route_t r;
        summ_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            r = group_route(g);
            if (|(live_i[g] & r.lo_sel)) summ_o[r.lo_pos] = 1'b1;
            if (|(live_i[g] & r.hi_sel)) summ_o[r.hi_pos] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_regif.sv
// Module: register port of the controller. Decodes the byte address into
// per-group write strobes and a master write strobe, and returns read data
// registered one cycle after the read strobe.
// Assumes word-aligned addresses (bits 1:0 are ignored).
module irq_regif
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int ADDR_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          wr_i,
    input  logic                          rd_i,
    input  logic [NUM_GRP-1:0][REG_W-1:0] status_i,
    input  logic [NUM_GRP-1:0][REG_W-1:0] mask_i,
    input  logic [NUM_GRP-1:0][REG_W-1:0] ident_i,
    input  logic [NUM_GRP-1:0][REG_W-1:0] enable_i,
    input  logic [REG_W-1:0]              master_i,
    output logic [NUM_GRP-1:0]            grp_wr_o,
    output grp_reg_e                      reg_sel_o,
    output logic                          master_wr_o,
    output logic [REG_W-1:0]              rdata_o,
    output logic                          rvalid_o
);

    localparam int GW = ADDR_W - 4;
    localparam logic [ADDR_W-3:0] MASTER_WORD = (ADDR_W-2)'(NUM_GRP * 4);

    logic [GW-1:0]    grp_idx;
    logic             grp_hit;
    logic             master_hit;
    logic [REG_W-1:0] rd_val;

    // Address fields and hit flags.
    always_comb begin
        grp_idx    = addr_i[ADDR_W-1:4];
        reg_sel_o  = grp_reg_e'(addr_i[3:2]);
        grp_hit    = {1'b0, grp_idx} < (GW+1)'(NUM_GRP);
        master_hit = addr_i[ADDR_W-1:2] == MASTER_WORD;
    end

    // Per-group write strobes.
    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_wr
            assign grp_wr_o[g] = wr_i && grp_hit && (grp_idx == GW'(g));
        end
    endgenerate

    // Master write strobe.
    always_comb master_wr_o = wr_i && master_hit;

    // Read multiplexer over groups and master; unmapped reads give zero.
    always_comb begin
        rd_val = '0;
        if (master_hit) begin
            rd_val = master_i;
        end else if (grp_hit) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (grp_idx == GW'(g)) begin
                    case (reg_sel_o)
                        SEL_STATUS: rd_val = status_i[g];
                        SEL_MASK:   rd_val = mask_i[g];
                        SEL_IDENT:  rd_val = ident_i[g];
                        SEL_ENABLE: rd_val = enable_i[g];
                        default:    rd_val = '0;
                    endcase
                end
            end
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i) rdata_o <= rd_val;
        end
    end

    p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);

endmodule

// File: rtl/irq_agg_ctrl.sv
// Module: top of the two-level interrupt aggregation controller.
// Instantiates the groups, the summary reduction and the register port,
// and holds the master enable bit that gates the level output.
// Assumes NUM_GRP between 1 and 11 and an 8-bit or wider byte address.
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int ADDR_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP*REG_W-1:0]   evt_i,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    output logic                       bus_rvalid,
    output logic                       irq_o
);

    logic [NUM_GRP-1:0][REG_W-1:0] evt_arr;
    logic [NUM_GRP-1:0][REG_W-1:0] mask_arr;
    logic [NUM_GRP-1:0][REG_W-1:0] ident_arr;
    logic [NUM_GRP-1:0][REG_W-1:0] enable_arr;
    logic [NUM_GRP-1:0][REG_W-1:0] live_arr;
    logic [NUM_GRP-1:0]            grp_wr;
    grp_reg_e                      reg_sel;
    logic                          master_wr;
    logic                          master_en;
    logic [REG_W-2:0]              summ;
    logic [REG_W-1:0]              master_val;
    logic                          any_live;

    // Second-level groups.
    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign evt_arr[g] = evt_i[g*REG_W +: REG_W];
            irq_group u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_i    (evt_arr[g]),
                .wr_i     (grp_wr[g]),
                .wr_sel_i (reg_sel),
                .wdata_i  (bus_wdata),
                .mask_o   (mask_arr[g]),
                .ident_o  (ident_arr[g]),
                .enable_o (enable_arr[g]),
                .live_o   (live_arr[g])
            );
        end
    endgenerate

    irq_summary #(.NUM_GRP(NUM_GRP)) u_summ (
        .live_i (live_arr),
        .summ_o (summ)
    );

    irq_regif #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .rd_i        (bus_rd),
        .status_i    (evt_arr),
        .mask_i      (mask_arr),
        .ident_i     (ident_arr),
        .enable_i    (enable_arr),
        .master_i    (master_val),
        .grp_wr_o    (grp_wr),
        .reg_sel_o   (reg_sel),
        .master_wr_o (master_wr),
        .rdata_o     (bus_rdata),
        .rvalid_o    (bus_rvalid)
    );

    // Master enable: the only writable master bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         master_en <= 1'b0;
        else if (master_wr) master_en <= bus_wdata[REG_W-1];
    end

    // Master register view and gated level output.
    always_comb begin
        master_val = {master_en, summ};
        irq_o      = master_en & (|summ);
        any_live   = |live_arr;
    end

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> master_en);

    p_master_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_wr |=> $stable(master_en));

    p_summary_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|summ) |-> any_live);

endmodule

// File: tb/irq_agg_ctrl_tb.sv
module irq_agg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [255:0]  evt = '0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          irq_o;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_tag = "";

    // Reference state.
    logic [31:0] m_mask [NG];
    logic [31:0] m_iden [NG];
    logic [31:0] m_enab [NG];
    logic        m_men;
    logic [31:0] exp_rd;
    logic        exp_rv;
    logic        exp_irq;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o      (irq_o)
    );

    function automatic logic [31:0] model_master();
        logic [31:0] m = '0;
        logic [31:0] q [NG];
        for (int g = 0; g < NG; g++) q[g] = m_iden[g] & m_enab[g];
        m[0]  = |q[0][15:0];
        m[1]  = |q[0][31:16];
        m[2]  = |q[1][15:0];
        m[3]  = |q[1][31:16];
        m[4]  = |q[2][15:0];
        m[6]  = |q[3][15:0];
        m[16] = |q[4];
        m[17] = |q[5];
        m[18] = |q[6];
        m[20] = |q[7];
        m[31] = m_men;
        return m;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int g = a / 16;
        int r = (a % 16) / 4;
        if (a[7:2] == 6'h20) return model_master();
        if (g >= NG) return 32'h0;
        case (r)
            0: return evt[g*32 +: 32];
            1: return m_mask[g];
            2: return m_iden[g];
            default: return m_enab[g];
        endcase
    endfunction

    // Cycle model, updated at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_mask[g] = '1; m_iden[g] = '0; m_enab[g] = '0;
            end
            m_men = 1'b0; exp_rv = 1'b0; exp_rd = '0; exp_tag = "";
        end else begin
            exp_rv = bus_rd;
            if (bus_rd) begin
                exp_rd  = model_read(bus_addr);
                exp_tag = cur_tag;
            end
            for (int g = 0; g < NG; g++) begin
                logic [31:0] clr;
                clr = (bus_wr && bus_addr == 8'(g*16 + 8)) ? bus_wdata : 32'h0;
                m_iden[g] = (m_iden[g] & ~clr) | (evt[g*32 +: 32] & ~m_mask[g]);
            end
            if (bus_wr) begin
                for (int g = 0; g < NG; g++) begin
                    if (bus_addr == 8'(g*16 + 4))  m_mask[g] = bus_wdata;
                    if (bus_addr == 8'(g*16 + 12)) m_enab[g] = bus_wdata;
                end
                if (bus_addr == 8'h80) m_men = bus_wdata[31];
            end
        end
        exp_irq = m_men && (model_master() & 32'h7FFF_FFFF) != 0;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at cycle %0d", tag, act, expv, cycles);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            check(irq_o === exp_irq, rst_n ? "R7 irq level" : "R1 irq in reset", 32'(irq_o), 32'(exp_irq));
            check(bus_rvalid === exp_rv, "R10 read valid", 32'(bus_rvalid), 32'(exp_rv));
            if (exp_rv) check(bus_rdata === exp_rd, exp_tag, bus_rdata, exp_rd);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                       input logic [31:0] d, input logic [255:0] e, input string t);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt = e; cur_tag = t;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, '0, "");
    endtask

    task automatic rd(input logic [7:0] a, input string t);
        cyc(1'b0, 1'b1, a, 32'h0, '0, t);
    endtask

    task automatic pulse(input int g, input logic [31:0] bits);
        logic [255:0] e = '0;
        e[g*32 +: 32] = bits;
        cyc(1'b0, 1'b0, 8'h00, 32'h0, e, "");
    endtask

    function automatic logic [7:0] ra(input int g, input int r);
        return 8'(g*16 + r*4);
    endfunction

    initial begin
        logic [255:0] e;
        repeat (2) @(posedge clk);
        @(negedge clk); armed = 1;
        @(negedge clk); rst_n = 1'b1;

        // R1: reset contents of every register.
        for (int g = 0; g < NG; g++)
            for (int r = 0; r < 4; r++) rd(ra(g, r), "R1 reset value");
        rd(8'h80, "R1 master reset value");

        // R2: masked event is dropped and not deferred.
        pulse(0, 32'h8);
        rd(ra(0, 2), "R2 masked event dropped");
        wr(ra(0, 1), 32'hFFFF_FFF0);
        rd(ra(0, 1), "R4 mask full replace");
        rd(ra(0, 2), "R2 no deferred set after unmask");
        pulse(0, 32'h8);
        rd(ra(0, 2), "R2 unmasked event sets");

        // R5/R7: enable routes to master bit 0; output still gated.
        wr(ra(0, 3), 32'h8);
        rd(8'h80, "R5 group0 low half");
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, "R6 only top bit written");
        wr(8'h80, 32'h0);
        rd(8'h80, "R6 summary bits not writable");
        wr(8'h80, 32'h8000_0000);
        rd(8'h80, "R7 enabled with source");

        // R3/R11: clear and partial clear.
        wr(ra(0, 2), 32'h8);
        rd(ra(0, 2), "R3 identity cleared");
        rd(8'h80, "R11 summary drops after clear");
        pulse(0, 32'hE);
        wr(ra(0, 2), 32'h2);
        rd(ra(0, 2), "R3 partial clear keeps others");

        // R8: event and clear on the same bit in one cycle.
        e = '0; e[2] = 1'b1;
        cyc(1'b1, 1'b0, ra(0, 2), 32'h4, e, "");
        rd(ra(0, 2), "R8 event wins over clear");

        // R5: upper half of group 0.
        wr(ra(0, 2), 32'hFFFF_FFFF);
        wr(ra(0, 1), 32'h0);
        wr(ra(0, 3), 32'hFFFF_FFFF);
        pulse(0, 32'h0010_0000);
        rd(8'h80, "R5 group0 high half");

        // R5: remaining groups, upper bit first then bit 0.
        for (int g = 1; g < NG; g++) begin
            wr(ra(g, 1), 32'h0);
            wr(ra(g, 3), 32'hFFFF_FFFF);
            pulse(g, 32'h8000_0000);
            rd(8'h80, "R5 routing of upper bit");
            pulse(g, 32'h0000_0001);
            rd(8'h80, "R5 routing of low bit");
        end

        // R9: status is live and read-only.
        e = '0; e[5*32 +: 32] = 32'h5A5A_00C3;
        cyc(1'b0, 1'b1, ra(5, 0), 32'h0, e, "R9 status live value");
        wr(ra(5, 0), 32'hFFFF_FFFF);
        rd(ra(5, 0), "R9 status write ignored");
        rd(ra(5, 1), "R9 status write leaves mask");

        // R10: unmapped offsets and read-before-write ordering.
        rd(8'hC0, "R10 unmapped read");
        rd(8'h84, "R10 unmapped read");
        cyc(1'b1, 1'b1, ra(3, 3), 32'h1234_0000, '0, "R10 read shows old value");
        rd(ra(3, 3), "R10 written value");

        // R4: enable write re-evaluates the summary.
        wr(ra(0, 3), 32'h0);
        rd(8'h80, "R4 enable write re-evaluates");

        // R11: clear everything; output must fall.
        for (int g = 0; g < NG; g++) wr(ra(g, 2), 32'hFFFF_FFFF);
        rd(8'h80, "R11 all summaries cleared");
        repeat (3) cyc(1'b0, 1'b0, 8'h0, 32'h0, '0, "");
        @(negedge clk);
        finish_run();
    end

endmodule